// File: doc/BRIEF.md
# Real-Time Clock and Calendar with Events and Alarm

This block keeps the time of day and the calendar date in BCD. It advances by one second for each accepted pulse on a once-per-second tick input. Each accepted tick raises a second event. It can also raise one selectable time event and one selectable calendar event, and an alarm pulse when the new time and date match the enabled alarm fields. Hours run in either 24-hour or 12-hour mode, with an AM/PM bit in 12-hour mode.

To load a new time or date, software raises an update request. It waits for the acknowledge, which stops the count, and then writes the new value. When it drops the request, counting resumes from the written value. A write that holds an out-of-range value is refused, and the matching invalid-entry flag is raised. Alarm words can be written at any time and go through the same range checks.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time is 00:00:00 with PM clear. The calendar is century 0x20, year 0x00, month 0x01, weekday 6, date 0x01. All events, the acknowledge and all invalid flags are 0.
- R2: Time word layout: seconds in bits 6:0, minutes in bits 14:8, hour in bits 21:16, PM in bit 22. Bits 7 and 15 read 0. A tick taken while upd_ack is 0 advances the time by one BCD second on the next clock edge. sec_evt is 1 in exactly that following cycle.
- R3: In 24-hour mode (hour12=0) the hour wraps from 23 to 00, and that wrap starts a new day. In 12-hour mode the hour runs 12, 01, ..., 11. PM toggles on the step from 11 to 12, and a new day starts when 11 PM steps to 12 AM.
- R4: Calendar word layout: century in bits 6:0, year in bits 15:8, month in bits 20:16, weekday in bits 23:21 (1 is Monday, 7 is Sunday), date in bits 29:24. On a new day the weekday steps from 7 to 1. The date follows the month length, and February has 29 days when the year is a multiple of 4. December wraps to January. Year 99 wraps to 00 and the century advances.
- R5: time_evt pulses together with sec_evt, as chosen by tev_sel: 0 on a minute change, 1 on an hour change, 2 at the start of a day, 3 at noon (12:00:00, with PM set in 12-hour mode).
- R6: cal_evt pulses at the start of a day, as chosen by cev_sel: 0 when the new weekday is 1, 1 when the new date is 01, 2 when the new date is 01 of month 01. Value 3 never fires.
- R7: Time alarm word: seconds 6:0 with enable bit 7, minutes 14:8 with enable 15, hour 21:16 with PM 22 and enable 23. The PM bit is compared only in 12-hour mode. Date alarm word: month 4:0 with enable 5, date 11:6 with enable 12. alarm_evt pulses with sec_evt when every enabled field equals the new value. Disabled fields are ignored, and the alarm never fires with no field enabled.
- R8: upd_ack is 1 in the cycle after either update request is high and 0 in the cycle after both are low. time_wr loads only while upd_ack and upd_time_req are both 1. cal_wr loads only while upd_ack and upd_cal_req are both 1. Other writes change nothing.
- R9: Ticks that arrive while upd_ack is 1 are dropped: no time change and no event.
- R10: A time write is refused and sets bad_time in any of these cases: seconds or minutes are not BCD 00-59; bit 7 or bit 15 is set; in 24-hour mode the hour is above 23 or PM is set; in 12-hour mode the hour is outside 01-12. An accepted time write clears bad_time.
- R11: A calendar write is refused and sets bad_cal in any of these cases: a digit is above 9; bit 7 is set; the month is outside 01-12; the weekday is outside 1-7; the date is outside 01 to that month's length. An accepted calendar write clears bad_cal.
- R12: An alarm write with an enabled field out of range is refused and sets bad_talm or bad_calm. A valid alarm write clears the flag. Disabled fields are not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per second |
| hour12 | input | 1 | 1 selects 12-hour mode |
| tev_sel | input | 2 | Time event select |
| cev_sel | input | 2 | Calendar event select |
| upd_time_req | input | 1 | Request to update the time |
| upd_cal_req | input | 1 | Request to update the calendar |
| time_wr | input | 1 | Time write strobe |
| time_in | input | 23 | New time word |
| cal_wr | input | 1 | Calendar write strobe |
| cal_in | input | 30 | New calendar word |
| talm_wr | input | 1 | Time alarm write strobe |
| talm_in | input | 24 | Time alarm word |
| calm_wr | input | 1 | Date alarm write strobe |
| calm_in | input | 13 | Date alarm word |
| time_now | output | 23 | Current time |
| cal_now | output | 30 | Current calendar |
| sec_evt | output | 1 | Second event pulse |
| time_evt | output | 1 | Selected time event pulse |
| cal_evt | output | 1 | Selected calendar event pulse |
| alarm_evt | output | 1 | Alarm match pulse |
| upd_ack | output | 1 | Update acknowledge, counting stopped |
| bad_time | output | 1 | Last time write refused |
| bad_cal | output | 1 | Last calendar write refused |
| bad_talm | output | 1 | Last time alarm write refused |
| bad_calm | output | 1 | Last date alarm write refused |

## Verification
The hardest conditions to reach are the rare rollovers. These are 11 PM to 12 AM in 12-hour mode, the end of February in leap and common years, and year 99 rolling into a new century. Waiting for any of them tick by tick would take far too long. Instead, the bench uses the update handshake to load a time and date one second before each boundary, then sends a single tick. It checks the new word and every event pulse in the cycle after that tick.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter logic [29:0] CAL_RESET = 30'h01C1_0020
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        hour12,
  input  logic [1:0]  tev_sel,
  input  logic [1:0]  cev_sel,
  input  logic        upd_time_req,
  input  logic        upd_cal_req,
  input  logic        time_wr,
  input  logic [22:0] time_in,
  input  logic        cal_wr,
  input  logic [29:0] cal_in,
  input  logic        talm_wr,
  input  logic [23:0] talm_in,
  input  logic        calm_wr,
  input  logic [12:0] calm_in,
  output logic [22:0] time_now,
  output logic [29:0] cal_now,
  output logic        sec_evt,
  output logic        time_evt,
  output logic        cal_evt,
  output logic        alarm_evt,
  output logic        upd_ack,
  output logic        bad_time,
  output logic        bad_cal,
  output logic        bad_talm,
  output logic        bad_calm
);

  function automatic logic [7:0] inc8(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic okr(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic leap(input logic [7:0] y);
    return y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6) : (y[1:0] == 2'd0);
  endfunction

  function automatic logic [7:0] mlen(input logic [7:0] mo, input logic lp);
    case (mo)
      8'h02:                      return lp ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  logic [6:0] sec, min, cent;
  logic [5:0] hr, date;
  logic       pm;
  logic [7:0] yr;
  logic [4:0] mon;
  logic [2:0] dow;
  logic [23:0] talm;
  logic [12:0] calm;

  assign time_now = {pm, hr, 1'b0, min, 1'b0, sec};
  assign cal_now  = {date, dow, mon, yr, 1'b0, cent};

  logic [7:0] ns, nm, nh, ndt, nmo, ny;
  logic [6:0] nc;
  logic [2:0] ndow;
  logic       npm, sw, mw, dw;

  always_comb begin
    sw  = ({1'b0, sec} == 8'h59);
    mw  = sw && ({1'b0, min} == 8'h59);
    ns  = sw ? 8'h00 : inc8({1'b0, sec});
    nm  = mw ? 8'h00 : (sw ? inc8({1'b0, min}) : {1'b0, min});
    nh  = {2'b0, hr};
    npm = pm;
    dw  = 1'b0;
    if (mw) begin
      if (!hour12) begin
        if (nh == 8'h23) begin nh = 8'h00; dw = 1'b1; end
        else nh = inc8(nh);
      end else begin
        if (nh == 8'h12) nh = 8'h01;
        else if (nh == 8'h11) begin nh = 8'h12; npm = ~pm; dw = pm; end
        else nh = inc8(nh);
      end
    end
    ndow = dow;
    ndt  = {2'b0, date};
    nmo  = {3'b0, mon};
    ny   = yr;
    nc   = cent;
    if (dw) begin
      ndow = (dow == 3'd7) ? 3'd1 : dow + 3'd1;
      if (ndt == mlen(nmo, leap(yr))) begin
        ndt = 8'h01;
        if (nmo == 8'h12) begin
          nmo = 8'h01;
          if (yr == 8'h99) begin
            ny = 8'h00;
            nc = (cent[3:0] == 4'd9) ? {cent[6:4] + 3'd1, 4'd0} : cent + 7'd1;
          end else ny = inc8(yr);
        end else nmo = inc8(nmo);
      end else ndt = inc8(ndt);
    end
  end

  logic tev, cev, hit, any_en;
  always_comb begin
    case (tev_sel)
      2'd0:    tev = sw;
      2'd1:    tev = mw;
      2'd2:    tev = dw;
      default: tev = mw && nh == 8'h12 && (!hour12 || npm);
    endcase
    case (cev_sel)
      2'd0:    cev = dw && ndow == 3'd1;
      2'd1:    cev = dw && ndt == 8'h01;
      2'd2:    cev = dw && ndt == 8'h01 && nmo == 8'h01;
      default: cev = 1'b0;
    endcase
  end

  assign any_en = talm[7] | talm[15] | talm[23] | calm[5] | calm[12];
  assign hit = any_en
    && (!talm[7]  || ns == {1'b0, talm[6:0]})
    && (!talm[15] || nm == {1'b0, talm[14:8]})
    && (!talm[23] || (nh == {2'b0, talm[21:16]} && (!hour12 || npm == talm[22])))
    && (!calm[5]  || nmo == {3'b0, calm[4:0]})
    && (!calm[12] || ndt == {2'b0, calm[11:6]});

  logic t_ok, c_ok, ta_ok, ca_ok, hr_ok;
  assign hr_ok = hour12 ? okr({2'b0, time_in[21:16]}, 8'h01, 8'h12)
                        : (okr({2'b0, time_in[21:16]}, 8'h00, 8'h23) && !time_in[22]);
  assign t_ok = okr({1'b0, time_in[6:0]}, 8'h00, 8'h59) && okr({1'b0, time_in[14:8]}, 8'h00, 8'h59)
             && !time_in[7] && !time_in[15] && hr_ok;
  assign c_ok = okr({1'b0, cal_in[6:0]}, 8'h00, 8'h79) && !cal_in[7]
             && (cal_in[15:12] <= 4'd9) && okr(cal_in[15:8], 8'h00, 8'h99)
             && okr({3'b0, cal_in[20:16]}, 8'h01, 8'h12)
             && cal_in[23:21] != 3'd0
             && okr({2'b0, cal_in[29:24]}, 8'h01, mlen({3'b0, cal_in[20:16]}, leap(cal_in[15:8])));
  assign ta_ok = (!talm_in[7]  || okr({1'b0, talm_in[6:0]}, 8'h00, 8'h59))
              && (!talm_in[15] || okr({1'b0, talm_in[14:8]}, 8'h00, 8'h59))
              && (!talm_in[23] || (hour12 ? okr({2'b0, talm_in[21:16]}, 8'h01, 8'h12)
                                          : (okr({2'b0, talm_in[21:16]}, 8'h00, 8'h23) && !talm_in[22])));
  assign ca_ok = (!calm_in[5]  || okr({3'b0, calm_in[4:0]}, 8'h01, 8'h12))
              && (!calm_in[12] || okr({2'b0, calm_in[11:6]}, 8'h01, 8'h31));

  logic step, twr, cwr;
  assign step = tick && !upd_ack;
  assign twr  = time_wr && upd_ack && upd_time_req;
  assign cwr  = cal_wr && upd_ack && upd_cal_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sec, min, hr, pm} <= '0;
      {date, dow, mon, yr} <= {CAL_RESET[29:8]};
      cent <= CAL_RESET[6:0];
      talm <= '0;
      calm <= '0;
      {sec_evt, time_evt, cal_evt, alarm_evt, upd_ack} <= '0;
      {bad_time, bad_cal, bad_talm, bad_calm} <= '0;
    end else begin
      upd_ack   <= upd_time_req | upd_cal_req;
      sec_evt   <= step;
      time_evt  <= step && tev;
      cal_evt   <= step && cev;
      alarm_evt <= step && hit;
      if (step) begin
        sec <= ns[6:0]; min <= nm[6:0]; hr <= nh[5:0]; pm <= npm;
        date <= ndt[5:0]; dow <= ndow; mon <= nmo[4:0]; yr <= ny; cent <= nc;
      end
      if (twr) begin
        bad_time <= !t_ok;
        if (t_ok) begin
          sec <= time_in[6:0]; min <= time_in[14:8]; hr <= time_in[21:16]; pm <= time_in[22];
        end
      end
      if (cwr) begin
        bad_cal <= !c_ok;
        if (c_ok) begin
          cent <= cal_in[6:0]; yr <= cal_in[15:8]; mon <= cal_in[20:16];
          dow <= cal_in[23:21]; date <= cal_in[29:24];
        end
      end
      if (talm_wr) begin
        bad_talm <= !ta_ok;
        if (ta_ok) talm <= talm_in;
      end
      if (calm_wr) begin
        bad_calm <= !ca_ok;
        if (ca_ok) calm <= calm_in;
      end
    end
  end

endmodule

module rtc_calendar_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        upd_time_req,
  input logic        upd_cal_req,
  input logic        time_wr,
  input logic [22:0] time_now,
  input logic        sec_evt,
  input logic        time_evt,
  input logic        cal_evt,
  input logic        alarm_evt,
  input logic        upd_ack
);

  assert_sec_from_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |-> ($past(tick) && !$past(upd_ack)));

  assert_sec_bcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (time_now[3:0] <= 4'd9) && (time_now[6:0] <= 7'h59));

  assert_ack_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_time_req || upd_cal_req) |=> upd_ack);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ack && !time_wr) |=> $stable(time_now));

  assert_time_evt_on_minute_R5: assert property (@(posedge clk) disable iff (!rst_n)
    time_evt |-> (sec_evt && time_now[6:0] == 7'h00));

  assert_cal_evt_day_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_evt |-> (sec_evt && time_now[15:0] == 16'h0000));

  assert_alarm_on_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |-> sec_evt);

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (.*);

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, tick = 0, hour12 = 0;
  logic [1:0]  tev_sel = 0, cev_sel = 3;
  logic        upd_time_req = 0, upd_cal_req = 0;
  logic        time_wr = 0, cal_wr = 0, talm_wr = 0, calm_wr = 0;
  logic [22:0] time_in = 0;
  logic [29:0] cal_in = 0;
  logic [23:0] talm_in = 0;
  logic [12:0] calm_in = 0;
  logic [22:0] time_now;
  logic [29:0] cal_now;
  logic sec_evt, time_evt, cal_evt, alarm_evt, upd_ack;
  logic bad_time, bad_cal, bad_talm, bad_calm;
  int checks = 0, errors = 0;

  rtc_calendar uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [22:0] tw(input logic p, input logic [7:0] h, m, s);
    return {p, h[5:0], 1'b0, m[6:0], 1'b0, s[6:0]};
  endfunction

  function automatic logic [29:0] cw(input logic [7:0] c, y, mo, input logic [2:0] d, input logic [7:0] dt);
    return {dt[5:0], d, mo[4:0], y, 1'b0, c[6:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step1();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic set_time(input logic [22:0] t);
    @(negedge clk) upd_time_req = 1;
    @(negedge clk) begin time_wr = 1; time_in = t; end
    @(negedge clk) begin time_wr = 0; upd_time_req = 0; end
    @(negedge clk);
  endtask

  task automatic set_cal(input logic [29:0] c);
    @(negedge clk) upd_cal_req = 1;
    @(negedge clk) begin cal_wr = 1; cal_in = c; end
    @(negedge clk) begin cal_wr = 0; upd_cal_req = 0; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 time", time_now, 0);
    chk("R1 cal", cal_now, cw(8'h20, 8'h00, 8'h01, 6, 8'h01));
    chk("R1 outs", {sec_evt, time_evt, cal_evt, alarm_evt, upd_ack, bad_time, bad_cal, bad_talm, bad_calm}, 0);
  endtask

  task automatic t_seconds();
    step1();
    chk("R2 first tick", time_now, tw(0, 8'h00, 8'h00, 8'h01));
    chk("R2 sec_evt", sec_evt, 1);
    @(negedge clk);
    chk("R2 sec_evt one cycle", sec_evt, 0);
    set_time(tw(0, 8'h00, 8'h00, 8'h09));
    step1();
    chk("R2 bcd carry", time_now, tw(0, 8'h00, 8'h00, 8'h10));
  endtask

  task automatic t_day24();
    tev_sel = 0; cev_sel = 1;
    set_cal(cw(8'h20, 8'h00, 8'h01, 1, 8'h31));
    set_time(tw(0, 8'h23, 8'h59, 8'h59));
    step1();
    chk("R3 24h wrap", time_now, 0);
    chk("R4 month end", cal_now, cw(8'h20, 8'h00, 8'h02, 2, 8'h01));
    chk("R5 minute event", time_evt, 1);
    chk("R6 month event", cal_evt, 1);
  endtask

  task automatic t_leap();
    cev_sel = 3;
    set_cal(cw(8'h20, 8'h24, 8'h02, 3, 8'h28));
    set_time(tw(0, 8'h23, 8'h59, 8'h59));
    step1();
    chk("R4 leap 29", cal_now, cw(8'h20, 8'h24, 8'h02, 4, 8'h29));
    chk("R6 sel 3 never", cal_evt, 0);
    set_time(tw(0, 8'h23, 8'h59, 8'h59));
    step1();
    chk("R4 leap to march", cal_now, cw(8'h20, 8'h24, 8'h03, 5, 8'h01));
    set_cal(cw(8'h20, 8'h23, 8'h02, 2, 8'h28));
    set_time(tw(0, 8'h23, 8'h59, 8'h59));
    step1();
    chk("R4 common feb", cal_now, cw(8'h20, 8'h23, 8'h03, 3, 8'h01));
  endtask

  task automatic t_year_week();
    cev_sel = 2;
    set_cal(cw(8'h20, 8'h99, 8'h12, 4, 8'h31));
    set_time(tw(0, 8'h23, 8'h59, 8'h59));
    step1();
    chk("R4 century", cal_now, cw(8'h21, 8'h00, 8'h01, 5, 8'h01));
    chk("R6 year event", cal_evt, 1);
    cev_sel = 0;
    set_cal(cw(8'h20, 8'h00, 8'h01, 7, 8'h02));
    set_time(tw(0, 8'h23, 8'h59, 8'h59));
    step1();
    chk("R4 weekday wrap", cal_now[23:21], 1);
    chk("R6 week event", cal_evt, 1);
  endtask

  task automatic t_tevents();
    tev_sel = 1;
    set_time(tw(0, 8'h10, 8'h58, 8'h59));
    step1();
    chk("R5 hour sel no fire", time_evt, 0);
    set_time(tw(0, 8'h10, 8'h59, 8'h59));
    step1();
    chk("R5 hour event", time_evt, 1);
    tev_sel = 2;
    set_time(tw(0, 8'h10, 8'h59, 8'h59));
    step1();
    chk("R5 midnight sel no fire", time_evt, 0);
    tev_sel = 3;
    set_time(tw(0, 8'h11, 8'h59, 8'h59));
    step1();
    chk("R5 noon 24h", {time_evt, time_now}, {1'b1, tw(0, 8'h12, 8'h00, 8'h00)});
  endtask

  task automatic t_12h();
    hour12 = 1; tev_sel = 3;
    set_time(tw(0, 8'h11, 8'h59, 8'h59));
    step1();
    chk("R3 11am to 12pm", time_now, tw(1, 8'h12, 8'h00, 8'h00));
    chk("R5 noon 12h", time_evt, 1);
    set_time(tw(1, 8'h12, 8'h59, 8'h59));
    step1();
    chk("R3 12 to 01", time_now, tw(1, 8'h01, 8'h00, 8'h00));
    tev_sel = 2;
    set_cal(cw(8'h20, 8'h00, 8'h01, 6, 8'h01));
    set_time(tw(1, 8'h11, 8'h59, 8'h59));
    step1();
    chk("R3 11pm to 12am", time_now, tw(0, 8'h12, 8'h00, 8'h00));
    chk("R3 new day 12h", cal_now, cw(8'h20, 8'h00, 8'h01, 7, 8'h02));
    chk("R5 midnight 12h", time_evt, 1);
    hour12 = 0;
  endtask

  task automatic t_invalid();
    set_time(tw(0, 8'h05, 8'h06, 8'h07));
    chk("R10 valid write", {bad_time, time_now}, {1'b0, tw(0, 8'h05, 8'h06, 8'h07)});
    set_time(tw(0, 8'h24, 8'h00, 8'h00));
    chk("R10 hour 24", {bad_time, time_now}, {1'b1, tw(0, 8'h05, 8'h06, 8'h07)});
    set_time(tw(0, 8'h05, 8'h06, 8'h07));
    set_time(tw(1, 8'h05, 8'h06, 8'h07));
    chk("R10 pm in 24h", bad_time, 1);
    set_time(tw(0, 8'h05, 8'h06, 8'h07));
    set_time(tw(0, 8'h05, 8'h60, 8'h07));
    chk("R10 minute 60", bad_time, 1);
    set_time(tw(0, 8'h05, 8'h06, 8'h07) | 23'h80);
    chk("R10 reserved bit", bad_time, 1);
    hour12 = 1;
    set_time(tw(0, 8'h00, 8'h00, 8'h00));
    chk("R10 12h hour 0", {bad_time, time_now}, {1'b1, tw(0, 8'h05, 8'h06, 8'h07)});
    hour12 = 0;
    set_time(tw(0, 8'h00, 8'h00, 8'h01));
    chk("R10 flag cleared", bad_time, 0);
    set_cal(cw(8'h20, 8'h10, 8'h05, 2, 8'h11));
    set_cal(cw(8'h20, 8'h10, 8'h13, 2, 8'h11));
    chk("R11 month 13", {bad_cal, cal_now}, {1'b1, cw(8'h20, 8'h10, 8'h05, 2, 8'h11)});
    set_cal(cw(8'h20, 8'h23, 8'h02, 2, 8'h29));
    chk("R11 feb 29 common", bad_cal, 1);
    set_cal(cw(8'h20, 8'h10, 8'h05, 0, 8'h11));
    chk("R11 weekday 0", bad_cal, 1);
    set_cal(cw(8'h20, 8'h24, 8'h02, 2, 8'h29));
    chk("R11 leap ok clears", {bad_cal, cal_now}, {1'b0, cw(8'h20, 8'h24, 8'h02, 2, 8'h29)});
  endtask

  task automatic t_freeze();
    set_time(tw(0, 8'h01, 8'h02, 8'h03));
    @(negedge clk) upd_time_req = 1;
    @(negedge clk);
    chk("R8 ack raised", upd_ack, 1);
    step1();
    chk("R9 tick dropped", {sec_evt, time_now}, {1'b0, tw(0, 8'h01, 8'h02, 8'h03)});
    @(negedge clk) begin time_wr = 1; time_in = tw(0, 8'h01, 8'h02, 8'h30); end
    @(negedge clk) begin time_wr = 0; upd_time_req = 0; end
    @(negedge clk);
    chk("R8 ack dropped", upd_ack, 0);
    step1();
    chk("R9 resume from write", time_now, tw(0, 8'h01, 8'h02, 8'h31));
    @(negedge clk) begin time_wr = 1; time_in = tw(0, 8'h09, 8'h09, 8'h09); end
    @(negedge clk) time_wr = 0;
    chk("R8 write without ack", {bad_time, time_now}, {1'b0, tw(0, 8'h01, 8'h02, 8'h31)});
    @(negedge clk) begin upd_cal_req = 1; end
    @(negedge clk) begin time_wr = 1; time_in = tw(0, 8'h09, 8'h09, 8'h09); end
    @(negedge clk) begin time_wr = 0; upd_cal_req = 0; end
    @(negedge clk);
    chk("R8 time write under cal req", time_now, tw(0, 8'h01, 8'h02, 8'h31));
  endtask

  task automatic t_alarm();
    @(negedge clk) begin talm_wr = 1; talm_in = {1'b0, 1'b0, 6'h00, 1'b0, 7'h33, 1'b1, 7'h05}; end
    @(negedge clk) talm_wr = 0;
    chk("R12 alarm ok", bad_talm, 0);
    set_time(tw(0, 8'h00, 8'h00, 8'h04));
    step1();
    chk("R7 second match", alarm_evt, 1);
    step1();
    chk("R7 no match", alarm_evt, 0);
    @(negedge clk) begin talm_wr = 1; talm_in = 0; calm_wr = 1; calm_in = {1'b1, 6'h02, 1'b0, 5'h00}; end
    @(negedge clk) begin talm_wr = 0; calm_wr = 0; end
    set_cal(cw(8'h20, 8'h00, 8'h01, 6, 8'h01));
    set_time(tw(0, 8'h23, 8'h59, 8'h59));
    step1();
    chk("R7 date match", alarm_evt, 1);
    @(negedge clk) begin calm_wr = 1; calm_in = 0; end
    @(negedge clk) calm_wr = 0;
    set_time(tw(0, 8'h00, 8'h00, 8'h04));
    step1();
    chk("R7 none enabled", alarm_evt, 0);
    @(negedge clk) begin talm_wr = 1; talm_in = {16'h0000, 1'b1, 7'h60}; end
    @(negedge clk) begin talm_wr = 0; end
    chk("R12 bad enabled sec", bad_talm, 1);
    @(negedge clk) begin talm_wr = 1; talm_in = {16'h0000, 1'b0, 7'h60}; end
    @(negedge clk) talm_wr = 0;
    chk("R12 disabled unchecked", bad_talm, 0);
    @(negedge clk) begin calm_wr = 1; calm_in = {1'b0, 6'h00, 1'b1, 5'h13}; end
    @(negedge clk) calm_wr = 0;
    chk("R12 bad month alarm", bad_calm, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_seconds();
    t_day24();
    t_leap();
    t_year_week();
    t_tevents();
    t_12h();
    t_invalid();
    t_freeze();
    t_alarm();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule